// File: doc/BRIEF.md
# Double-Data-Rate Sample Word Output Formatter

This block sits at the digital edge of a dual-rate converter output port. Once per conversion period it takes one sample word, either from the converter core or from a test pattern source, and maps it into the selected number format. It then serialises the word over half as many data lanes at double rate, next to a forwarded output clock that runs at the conversion rate.

Every lane carries one pair of adjacent bits. The odd-weighted bit of the pair is sent in the first half of the period and the even-weighted bit in the second half. A receiver therefore captures the odd bits on the falling edge of the forwarded clock and the even bits on its rising edge.

The block runs on a fast reference clock at `DIV` ticks per conversion period, and its own tick counter marks the word boundary. The phase of the forwarded clock is a 3-bit code, realised as a delay of a whole number of reference ticks. While the calibration or power-down condition `blank_i` is high, every output is held low.

Top module: `ddr_word_fmt`

## Requirements
- R1: After reset, all lanes and the forwarded clock stay low until the first word boundary, which is the 16th reference clock edge after reset is released.
- R2: A word is captured on the edge that moves the tick counter from DIV-1 to 0. During ticks 0..7 of the following period, lane k drives bit 2k+1 of the word. During ticks 8..15, it drives bit 2k.
- R3: With a delay of d ticks, the forwarded clock falls at tick d and rises at tick d+8 of each period. It is high during ticks 0..d-1 and d+8..15, which gives one cycle per word.
- R4: The phase code n selects 31+16n degrees. This is rounded to the nearest 22.5-degree tick, so codes 0..7 give d = 1,2,3,4,4,5,6,6. After reset, d is 4, which is code 4 (95 degrees).
- R5: When `twos_i` is 0, the output word equals the converter code unchanged (offset binary).
- R6: When `twos_i` is 1, the output word is the offset binary code with bit 15 inverted.
- R7: An under-range flag gives code 0x0000 and an over-range flag gives 0xFFFF before formatting. If both flags are set, over-range wins. With two's complement selected, these become 0x8000 and 0x7FFF.
- R8: When `pat_sel_i` is 1, the test word replaces the converter word, and the range flags are ignored. The format is applied to the test word unless `pat_raw_i` is 1, in which case the test word is sent unchanged.
- R9: While `blank_i` is high, every lane and the forwarded clock are low in that same tick. Tick counting continues, and the outputs resume mid-word when `blank_i` falls.
- R10: Changes to `twos_i` or `phase_i` in the middle of a word do not alter the word or clock phase being sent. They take effect from the next word boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock, DIV ticks per conversion period |
| rst_ni | input | 1 | Active-low asynchronous reset |
| adc_word_i | input | 16 | Converter sample in offset binary |
| adc_under_i | input | 1 | Converter input below range |
| adc_over_i | input | 1 | Converter input above range |
| pat_sel_i | input | 1 | Send the test word instead of the converter word |
| pat_word_i | input | 16 | Test pattern word |
| pat_raw_i | input | 1 | Send the test word without format conversion |
| twos_i | input | 1 | 1 selects two's complement, 0 selects offset binary |
| blank_i | input | 1 | Calibration or power-down: force all outputs low |
| phase_i | input | 3 | Forwarded clock phase code |
| lane_o | output | 8 | Double-rate data lanes |
| oclk_o | output | 1 | Forwarded output clock |

## Verification
The bench targets the following corner cases, and each one catches a specific kind of defect:
- Bit ordering: the word 0xA5C3 is sent so that a swap of odd and even bits, or a half-period shift, corrupts every lane in a visible way.
- Phase codes: all eight codes are swept, including the pairs that round to the same tick (codes 3 and 4, codes 6 and 7). A truncating or off-by-one table lands the clock edges one tick off.
- Range flags: both flags are exercised together in both formats, which catches a wrong priority or a conversion applied before the forcing.
- Test pattern: the pattern is sent with the raw bypass on and off, which exposes a missing or inverted bypass.
- Mid-word changes: the format and phase are changed in the middle of a word, so a design that does not latch them at the boundary splits that word.
- Blanking: a short blanking pulse in mid-word checks that forcing is immediate and that the tick count is kept.

// File: rtl/ddr_word_fmt.sv
module ddr_word_fmt #(
  parameter int WORD_W     = 16,
  parameter int DIV        = 16,
  parameter int PH_W       = 3,
  parameter int PH_DEFAULT = 4,
  localparam int LANES     = WORD_W / 2,
  localparam int CW        = $clog2(DIV)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] adc_word_i,
  input  logic              adc_under_i,
  input  logic              adc_over_i,
  input  logic              pat_sel_i,
  input  logic [WORD_W-1:0] pat_word_i,
  input  logic              pat_raw_i,
  input  logic              twos_i,
  input  logic              blank_i,
  input  logic [PH_W-1:0]   phase_i,
  output logic [LANES-1:0]  lane_o,
  output logic              oclk_o
);

  function automatic logic [CW-1:0] phase_ticks(input logic [PH_W-1:0] code);
    int deg;
    int t;
    deg = 31 + 16 * int'(code);
    t   = (2 * DIV * deg + 360) / 720;
    return t[CW-1:0];
  endfunction

  logic [CW-1:0]     tick_q;
  logic [CW-1:0]     dly_q;
  logic [WORD_W-1:0] word_q;
  logic              live_q;

  logic [WORD_W-1:0] conv_w;
  logic [WORD_W-1:0] src_w;
  logic              flip_msb;
  logic [WORD_W-1:0] fmt_w;
  logic [CW-1:0]     ph;
  logic              boundary;
  logic              show;
  logic              odd_half;
  logic [LANES-1:0]  pair_sel;

  assign conv_w   = adc_over_i  ? {WORD_W{1'b1}} :
                    adc_under_i ? {WORD_W{1'b0}} : adc_word_i;
  assign src_w    = pat_sel_i ? pat_word_i : conv_w;
  assign flip_msb = twos_i & ~(pat_sel_i & pat_raw_i);
  assign fmt_w    = {src_w[WORD_W-1] ^ flip_msb, src_w[WORD_W-2:0]};

  assign boundary = (tick_q == CW'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= '0;
      dly_q  <= phase_ticks(PH_DEFAULT[PH_W-1:0]);
      word_q <= '0;
      live_q <= 1'b0;
    end else begin
      tick_q <= tick_q + CW'(1);
      if (boundary) begin
        word_q <= fmt_w;
        dly_q  <= phase_ticks(phase_i);
        live_q <= 1'b1;
      end
    end
  end

  assign odd_half = ~tick_q[CW-1];
  assign ph       = tick_q - dly_q;
  assign show     = live_q & ~blank_i;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign pair_sel[k] = odd_half ? word_q[2*k+1] : word_q[2*k];
  end

  assign lane_o = show ? pair_sel : '0;
  assign oclk_o = show & ph[CW-1];

endmodule

// File: rtl/ddr_word_fmt_chk.sv
module ddr_word_fmt_chk #(
  parameter int LANES = 8,
  parameter int DIV   = 16,
  localparam int CW   = $clog2(DIV)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             blank_i,
  input logic             live_q,
  input logic [CW-1:0]    tick_q,
  input logic [LANES-1:0] lane_o,
  input logic             oclk_o
);

  p_quiet_until_first_word_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !live_q |-> (lane_o == '0 && !oclk_o));

  p_lane_hold_in_half_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!blank_i && !$past(blank_i) && tick_q != '0 && tick_q != CW'(DIV/2)) |-> $stable(lane_o));

  p_oclk_fall_odd_half_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(oclk_o) && !blank_i && !$past(blank_i)) |-> (tick_q < CW'(DIV/2)));

  p_oclk_rise_even_half_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(oclk_o) && !$past(blank_i) && $past(live_q)) |-> (tick_q >= CW'(DIV/2)));

  p_blank_forces_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_i |-> (lane_o == '0 && !oclk_o));

endmodule

bind ddr_word_fmt ddr_word_fmt_chk #(.LANES(LANES), .DIV(DIV)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .blank_i(blank_i),
  .live_q (live_q),
  .tick_q (tick_q),
  .lane_o (lane_o),
  .oclk_o (oclk_o)
);

// File: tb/ddr_word_fmt_tb_top.sv
module ddr_word_fmt_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] adc_word_i = '0;
  logic        adc_under_i = 1'b0;
  logic        adc_over_i = 1'b0;
  logic        pat_sel_i = 1'b0;
  logic [15:0] pat_word_i = '0;
  logic        pat_raw_i = 1'b0;
  logic        twos_i = 1'b0;
  logic        blank_i = 1'b0;
  logic [2:0]  phase_i = 3'd4;
  logic [7:0]  lane_o;
  logic        oclk_o;

  int n_chk = 0;
  int n_bad = 0;
  int tick = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  always @(posedge clk_i) if (rst_ni) tick <= (tick + 1) % 16;

  ddr_word_fmt dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .adc_word_i(adc_word_i),
    .adc_under_i(adc_under_i), .adc_over_i(adc_over_i),
    .pat_sel_i(pat_sel_i), .pat_word_i(pat_word_i), .pat_raw_i(pat_raw_i),
    .twos_i(twos_i), .blank_i(blank_i), .phase_i(phase_i),
    .lane_o(lane_o), .oclk_o(oclk_o)
  );

  function automatic logic [7:0] exp_lanes(input logic [15:0] w, input int t);
    logic [7:0] r;
    for (int k = 0; k < 8; k++) r[k] = (t < 8) ? w[2*k+1] : w[2*k];
    return r;
  endfunction

  function automatic logic exp_clk(input int d, input int t);
    return ((t - d + 16) % 16) >= 8;
  endfunction

  task automatic chk(input string req, input logic [7:0] le, input logic ce);
    n_chk++;
    if (lane_o !== le || oclk_o !== ce) begin
      n_bad++;
      $display("FAIL %s tick %0d: lanes=%h oclk=%b expected lanes=%h oclk=%b",
               req, tick, lane_o, oclk_o, le, ce);
    end
  endtask

  task automatic to_tick15;
    do @(negedge clk_i); while (tick != 15);
  endtask

  task automatic check_word(input string req, input logic [15:0] w, input int d);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk_i);
      chk(req, exp_lanes(w, i), exp_clk(d, i));
    end
  endtask

  task automatic run_word(input string req, input logic [15:0] adc, input logic und,
                          input logic ovr, input logic psel, input logic [15:0] pat,
                          input logic raw, input logic tw, input logic [2:0] ph,
                          input logic [15:0] w, input int d);
    to_tick15();
    adc_word_i = adc; adc_under_i = und; adc_over_i = ovr;
    pat_sel_i = psel; pat_word_i = pat; pat_raw_i = raw;
    twos_i = tw; phase_i = ph;
    check_word(req, w, d);
  endtask

  task automatic test_reset_r1;
    for (int i = 1; i < 15; i++) begin
      @(negedge clk_i);
      chk("R1", 8'h00, 1'b0);
    end
  endtask

  task automatic test_order_r2;
    run_word("R2 R3 R5", 16'hA5C3, 0, 0, 0, 16'h0, 0, 0, 3'd4, 16'hA5C3, 4);
    run_word("R2", 16'h0001, 0, 0, 0, 16'h0, 0, 0, 3'd4, 16'h0001, 4);
    run_word("R2", 16'h8000, 0, 0, 0, 16'h0, 0, 0, 3'd4, 16'h8000, 4);
  endtask

  task automatic test_twos_r6;
    run_word("R6", 16'hA5C3, 0, 0, 0, 16'h0, 0, 1, 3'd4, 16'h25C3, 4);
    run_word("R6", 16'h1234, 0, 0, 0, 16'h0, 0, 1, 3'd4, 16'h9234, 4);
  endtask

  task automatic test_phase_r4;
    int dt[8] = '{1, 2, 3, 4, 4, 5, 6, 6};
    for (int n = 0; n < 8; n++)
      run_word("R4 R3", 16'h6B1E, 0, 0, 0, 16'h0, 0, 0, 3'(n), 16'h6B1E, dt[n]);
  endtask

  task automatic test_range_r7;
    run_word("R7 under", 16'h1234, 1, 0, 0, 16'h0, 0, 0, 3'd4, 16'h0000, 4);
    run_word("R7 over", 16'h1234, 0, 1, 0, 16'h0, 0, 0, 3'd4, 16'hFFFF, 4);
    run_word("R7 under twos", 16'h1234, 1, 0, 0, 16'h0, 0, 1, 3'd4, 16'h8000, 4);
    run_word("R7 over twos", 16'h1234, 0, 1, 0, 16'h0, 0, 1, 3'd4, 16'h7FFF, 4);
    run_word("R7 both", 16'h1234, 1, 1, 0, 16'h0, 0, 0, 3'd4, 16'hFFFF, 4);
  endtask

  task automatic test_pattern_r8;
    run_word("R8 fmt", 16'h1234, 0, 0, 1, 16'h0F0F, 0, 1, 3'd4, 16'h8F0F, 4);
    run_word("R8 raw", 16'h1234, 0, 0, 1, 16'h0F0F, 1, 1, 3'd4, 16'h0F0F, 4);
    run_word("R8 ob", 16'h1234, 0, 0, 1, 16'h0F0F, 1, 0, 3'd4, 16'h0F0F, 4);
    run_word("R8 flags", 16'h1234, 1, 1, 1, 16'h3C3C, 0, 0, 3'd4, 16'h3C3C, 4);
  endtask

  task automatic test_blank_r9;
    to_tick15();
    adc_word_i = 16'h5A96; adc_under_i = 0; adc_over_i = 0; pat_sel_i = 0;
    twos_i = 0; phase_i = 3'd4; blank_i = 1;
    check_word("R9 full", 16'h0000, 99);
    blank_i = 0;
    to_tick15();
    for (int i = 0; i < 16; i++) begin
      @(negedge clk_i);
      if (i >= 7 && i <= 9) chk("R9 mid", 8'h00, 1'b0);
      else chk("R9 resume", exp_lanes(16'h5A96, i), exp_clk(4, i));
      if (i == 6) blank_i = 1;
      if (i == 9) blank_i = 0;
    end
  endtask

  task automatic test_midword_r10;
    to_tick15();
    adc_word_i = 16'hC3A5; adc_under_i = 0; adc_over_i = 0; pat_sel_i = 0;
    twos_i = 0; phase_i = 3'd4;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk_i);
      chk("R10 hold", exp_lanes(16'hC3A5, i), exp_clk(4, i));
      if (i == 5) begin twos_i = 1; phase_i = 3'd0; end
    end
    check_word("R10 next", 16'h43A5, 1);
  endtask

  function automatic logic exp_clk_blank(input int d, input int t);
    return (d == 99) ? 1'b0 : exp_clk(d, t);
  endfunction

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    test_reset_r1();
    test_order_r2();
    test_twos_r6();
    test_phase_r4();
    test_range_r7();
    test_pattern_r8();
    test_blank_r9();
    test_midword_r10();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule